// File: doc/BRIEF.md
# Chainable Synchronous Up-Counter with Preset

This block is a binary up-counter made of 4-bit slices that all update on the same rising clock edge. Each slice can be cleared to zero, preset from a data word, advanced by one, or left holding. Every operation is synchronous, and a fixed priority decides which one takes effect. Each slice has two enables. The count advances only when both are high. Only the second enable, the trickle enable, is passed on to the slice's terminal-count flag. That flag goes high when the slice reads all ones while its trickle enable is high.

The top module chains `N_SLICES` slices. The terminal-count flag of each slice drives the trickle enable of the slice above it. The external trickle enable feeds the lowest slice. Clear, load and the parallel enable go to every slice together, and each slice takes its own 4-bit field of the data word. A counter that wraps early is built by decoding the desired last value onto the active-low clear input. The count then goes back to zero on the edge after that value.

Top module: `casc_bin_counter`

## Requirements
- R1: While `clr_n` is low at a rising edge, the count becomes zero at that edge, whatever the levels of `ld_n`, `en_p` and `en_t`.
- R2: While `clr_n` is high and `ld_n` is low at a rising edge, the count takes the value of `din` at that edge, whatever the levels of both enables.
- R3: While `clr_n` and `ld_n` are high and both `en_p` and `en_t` are high, the full count increases by one at each rising edge.
- R4: While `clr_n` and `ld_n` are high and either `en_p` or `en_t` is low, the count holds its value.
- R5: `tc_out` is high exactly when `en_t` is high and every bit of `count` is one. It follows its inputs combinationally, with no clock delay, and `en_p` has no effect on it.
- R6: A slice whose 4 bits are all ones and whose trickle enable is high makes the slice above it advance on the same edge (for example, 0x0F goes to 0x10 in an 8-bit counter).
- R7: When counting is enabled, the all-ones count wraps to zero.
- R8: Taking `clr_n` low between clock edges leaves the count unchanged until the next rising edge.
- R9: Feeding `clr_n` with the inverse of a decode of count value K makes the count run through 0, 1, …, K and then return to 0.
- R10: Bits [4i+3:4i] of `din` are loaded into slice i, which drives bits [4i+3:4i] of `count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all slices |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous preset from `din`, active low |
| en_p | input | 1 | Parallel count enable, sent to every slice |
| en_t | input | 1 | Trickle enable of the lowest slice; also gates `tc_out` |
| din | input | 4*N_SLICES | Preset data, split into 4-bit fields per slice |
| count | output | 4*N_SLICES | Current count value |
| tc_out | output | 1 | High when `en_t` is high and the count is all ones |

## Verification
The bench targets the priority corners by asserting clear and load in the same cycle as both enables. A design with the order reversed would load or count instead of going to zero. It steps across the nibble boundary and across the all-ones wrap. A broken carry chain would leave the upper slice stuck, or would advance it on the wrong edge. It checks `tc_out` with `en_p` low and with only the low slice full. Either mistake would raise the flag early and make a chained counter skip ahead. It also drops clear in the middle of a cycle and runs a decoded modulus-6 sequence. An asynchronous clear would zero the count before the edge and shorten that sequence.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_LOAD  = 2'd2,
    OP_STEP  = 2'd3
  } slice_op_e;

  // Fixed priority: clear over load over count.
  function automatic slice_op_e pick_op(input logic clr_n, input logic ld_n,
                                        input logic en_p, input logic en_t);
    if (!clr_n)            return OP_CLEAR;
    else if (!ld_n)        return OP_LOAD;
    else if (en_p && en_t) return OP_STEP;
    else                   return OP_HOLD;
  endfunction

endpackage

// File: rtl/cbc_tc_gen.sv
module cbc_tc_gen #(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] q,
  input  logic               en_t,
  output logic               tc
);
  logic all_ones;
  assign all_ones = &q;
  assign tc       = en_t & all_ones;
endmodule

// File: rtl/cbc_slice.sv
module cbc_slice
  import cbc_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               ld_n,
  input  logic               en_p,
  input  logic               en_t,
  input  logic [SLICE_W-1:0] d,
  output logic [SLICE_W-1:0] q,
  output logic               tc
);
  localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

  slice_op_e          op;
  logic [SLICE_W-1:0] q_r;
  logic [SLICE_W-1:0] q_inc;

  assign op    = pick_op(clr_n, ld_n, en_p, en_t);
  assign q_inc = q_r + ONE;

  always_ff @(posedge clk) begin
    unique case (op)
      OP_CLEAR: q_r <= '0;
      OP_LOAD:  q_r <= d;
      OP_STEP:  q_r <= q_inc;
      default:  q_r <= q_r;
    endcase
  end

  assign q = q_r;

  cbc_tc_gen #(.SLICE_W(SLICE_W)) u_tc (
    .q    (q_r),
    .en_t (en_t),
    .tc   (tc)
  );
endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter #(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 2,
  localparam int TOTAL_W = SLICE_W * N_SLICES
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               ld_n,
  input  logic               en_p,
  input  logic               en_t,
  input  logic [TOTAL_W-1:0] din,
  output logic [TOTAL_W-1:0] count,
  output logic               tc_out
);
  // trickle[i] enables slice i; trickle[i+1] is slice i's terminal count.
  wire [N_SLICES:0] trickle;
  assign trickle[0] = en_t;

  for (genvar g = 0; g < N_SLICES; g++) begin : g_slice
    logic [SLICE_W-1:0] q_g;
    cbc_slice #(.SLICE_W(SLICE_W)) u_slice (
      .clk   (clk),
      .clr_n (clr_n),
      .ld_n  (ld_n),
      .en_p  (en_p),
      .en_t  (trickle[g]),
      .d     (din[g*SLICE_W +: SLICE_W]),
      .q     (q_g),
      .tc    (trickle[g+1])
    );
    assign count[g*SLICE_W +: SLICE_W] = q_g;
  end

  assign tc_out = trickle[N_SLICES];
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 2,
  localparam int TOTAL_W = SLICE_W * N_SLICES
) (
  input logic               clk,
  input logic               clr_n,
  input logic               ld_n,
  input logic               en_p,
  input logic               en_t,
  input logic [TOTAL_W-1:0] din,
  input logic [TOTAL_W-1:0] count,
  input logic               tc_out,
  input logic [N_SLICES:0]  trickle
);
  localparam logic [TOTAL_W-1:0] INC = TOTAL_W'(1);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (count == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !ld_n) |=> (count == $past(din)));

  p_step_r3: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && en_p && en_t) |=> (count == $past(count) + INC));

  p_hold_r4: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && !(en_p && en_t)) |=> $stable(count));

  p_tc_r5: assert property (@(posedge clk) disable iff (!armed)
    tc_out == (en_t && (&count)));

  p_carry_r6: assert property (@(posedge clk) disable iff (!armed)
    trickle[1] == (en_t && (&count[SLICE_W-1:0])));
endmodule

bind casc_bin_counter cbc_checker #(.SLICE_W(SLICE_W), .N_SLICES(N_SLICES)) u_cbc_checker (
  .clk     (clk),
  .clr_n   (clr_n),
  .ld_n    (ld_n),
  .en_p    (en_p),
  .en_t    (en_t),
  .din     (din),
  .count   (count),
  .tc_out  (tc_out),
  .trickle (trickle)
);

// File: tb/casc_bin_counter_bench.sv
`timescale 1ns/1ps
module casc_bin_counter_bench;
  localparam int SW = 4;
  localparam int NS = 2;
  localparam int TW = SW * NS;

  logic          clk = 1'b0;
  logic          clr_n, ld_n, en_p, en_t;
  logic [TW-1:0] din;
  logic [TW-1:0] count;
  logic          tc_out;
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  casc_bin_counter #(.SLICE_W(SW), .N_SLICES(NS)) u_casc_bin_counter (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
    .din(din), .count(count), .tc_out(tc_out)
  );

  // Bench restatement of the terminal-count rule.
  function automatic logic tc_model(input logic [TW-1:0] c, input logic t);
    return t && (c == {TW{1'b1}});
  endfunction

  task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic c, input logic l, input logic p, input logic t,
                       input logic [TW-1:0] d);
    clr_n = c; ld_n = l; en_p = p; en_t = t; din = d;
  endtask

  task automatic t_clear();
    drive(0, 1, 0, 0, '0); tick();
    check("R1 reset state", count, '0);
    check("R5 tc at zero", {7'd0, tc_out}, '0);
    drive(0, 0, 1, 1, 8'hA5); tick();
    check("R1 clear beats load and count", count, '0);
  endtask

  task automatic t_load();
    drive(1, 0, 0, 0, 8'hA5); tick();
    check("R2 load with enables low, R10 fields", count, 8'hA5);
    drive(1, 0, 1, 1, 8'h3C); tick();
    check("R2 load beats count", count, 8'h3C);
  endtask

  task automatic t_count();
    drive(1, 1, 1, 1, '0);
    tick(); tick(); tick();
    check("R3 count by one", count, 8'h3F);
    tick();
    check("R6 carry into upper slice", count, 8'h40);
  endtask

  task automatic t_hold();
    drive(1, 1, 0, 1, '0); tick();
    check("R4 hold en_p low", count, 8'h40);
    drive(1, 1, 1, 0, '0); tick();
    check("R4 hold en_t low", count, 8'h40);
  endtask

  task automatic t_tc();
    drive(1, 0, 0, 0, 8'h0F); tick();
    drive(1, 1, 0, 1, '0); #0.5;
    check("R5 tc low with only low slice full", {7'd0, tc_out}, {7'd0, tc_model(count, en_t)});
    drive(1, 0, 0, 0, 8'hFF); tick();
    drive(1, 1, 0, 1, '0); #0.5;
    check("R5 tc high with en_p low", {7'd0, tc_out}, 8'd1);
    en_t = 0; #0.5;
    check("R5 tc follows en_t without clock", {7'd0, tc_out}, 8'd0);
    en_t = 1; en_p = 1; tick();
    check("R7 wrap all ones to zero", count, '0);
    check("R5 tc low after wrap", {7'd0, tc_out}, 8'd0);
  endtask

  task automatic t_sync_clear();
    drive(1, 0, 0, 0, 8'h55); tick();
    #0.5 clr_n = 0; #1;
    check("R8 no asynchronous clear", count, 8'h55);
    tick();
    check("R8 clear lands on edge", count, '0);
  endtask

  task automatic t_modulus();
    logic [TW-1:0] exp_c = '0;
    drive(0, 1, 1, 1, '0); tick();
    for (int i = 0; i < 14; i++) begin
      clr_n = (count != 8'd5);
      tick();
      exp_c = (exp_c == 8'd5) ? '0 : exp_c + 8'd1;
      check("R9 decoded modulus-6", count, exp_c);
    end
  endtask

  initial begin
    drive(0, 1, 0, 0, '0);
    t_clear();
    t_load();
    t_count();
    t_hold();
    t_tc();
    t_sync_clear();
    t_modulus();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule